// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches 32 general-purpose input pins and turns selected conditions on them into one interrupt request. Each pin is synchronised into the clock domain and then checked by its own detector. The detector looks for either a level or an edge. For level detection, the active polarity can be chosen per pin. For edge detection, rising and falling edges can each be enabled per pin, or both together.

Each pin keeps one status bit. In hold mode, the bit records the event until software clears it. In through mode, the bit simply mirrors the detection condition. The status bits are ANDed with per-pin enable bits, and the results are ORed into one registered request line.

Software reaches the block through a small synchronous port with 16-bit data. Every per-pin function is split into two halves: the lower half serves pins 0–15 and the upper half serves pins 16–31. The two halves sit at consecutive even byte offsets.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration and enable register reads 0 and `irq` is low.
- R2: A write to a configuration register changes it on the next edge, and it then reads back the written value. Read data is registered and appears one cycle after the address is applied. The offsets are pairs at 0x08 (status), 0x0C (enable), 0x10 (trigger type), 0x14 (polarity), 0x18 (hold), 0x20 (falling) and 0x24 (rising); within each pair, +0 serves pins 0–15 and +2 serves pins 16–31. Any other offset reads 0.
- R3: With trigger type bit 0 (level) and hold bit 0 (through), a pin's status bit equals its level condition. The condition is true when the synchronised input matches the polarity bit (1 = active-high, 0 = active-low).
- R4: With level trigger and hold bit 1, the status bit is set on every cycle the level is active. A write-1 clear therefore takes effect only once the input has become inactive.
- R5: With trigger type bit 1 (edge), a rising edge is detected when the rising-select bit is 1, and a falling edge is detected when the falling-select bit is 1. An edge whose select bit is 0 leaves the status bit unchanged.
- R6: With edge trigger and hold bit 1, a detected edge sets the status bit, and the bit stays set until it is cleared. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: With edge trigger and through mode, an edge gives a status pulse, and therefore an `irq` pulse when enabled, exactly one cycle long.
- R8: `irq` is registered. It is high whenever any bit of (status AND enable) is 1, one cycle after that condition, and it is low whenever every enable bit is 0.
- R9: The upper register halves act on pins 16–31, with bit n of an upper half belonging to pin 16+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous pin inputs |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The detectors are driven with static levels of both polarities, with levels held across a clear, and with isolated rising and falling transitions, each under every relevant select setting. Comparing through and hold mode on the same stimulus separates a mirrored status bit from a latched one. Comparing a matching edge with a non-matching edge separates the rising and falling selects. Counting `irq` cycles around a single edge separates a one-cycle pulse from a latched request. A pin in the upper bank is exercised alongside one in the lower bank, which shows that both halves are decoded to the right pins.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*DW-1:0] pin_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int NP = 2 * DW;
  localparam logic [AW-1:0] O_STAT = AW'(8'h08);
  localparam logic [AW-1:0] O_EN   = AW'(8'h0C);
  localparam logic [AW-1:0] O_TYPE = AW'(8'h10);
  localparam logic [AW-1:0] O_POL  = AW'(8'h14);
  localparam logic [AW-1:0] O_HOLD = AW'(8'h18);
  localparam logic [AW-1:0] O_FALL = AW'(8'h20);
  localparam logic [AW-1:0] O_RISE = AW'(8'h24);

  logic [NP-1:0] sync1, cur, prev;
  logic [NP-1:0] en, typ, pol, hold, fall, rise, stat;
  logic [NP-1:0] lvl, edg, cond, clr;
  logic [DW-1:0] rd_next;
  logic          mapped;

  wire [AW-1:0] base = {reg_addr[AW-1:2], 2'b00};
  wire          hi   = reg_addr[1];

  assign lvl  = ~(cur ^ pol);
  assign edg  = (rise & cur & ~prev) | (fall & ~cur & prev);
  assign cond = (typ & edg) | (~typ & lvl);
  assign clr  = (reg_we && base == O_STAT && !reg_addr[0])
                ? (hi ? {reg_wdata, {DW{1'b0}}} : {{DW{1'b0}}, reg_wdata})
                : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      cur   <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      cur   <= sync1;
      prev  <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; typ <= '0; pol <= '0; hold <= '0; fall <= '0; rise <= '0;
    end else if (reg_we && !reg_addr[0]) begin
      case (base)
        O_EN:   if (hi) en[NP-1:DW]   <= reg_wdata; else en[DW-1:0]   <= reg_wdata;
        O_TYPE: if (hi) typ[NP-1:DW]  <= reg_wdata; else typ[DW-1:0]  <= reg_wdata;
        O_POL:  if (hi) pol[NP-1:DW]  <= reg_wdata; else pol[DW-1:0]  <= reg_wdata;
        O_HOLD: if (hi) hold[NP-1:DW] <= reg_wdata; else hold[DW-1:0] <= reg_wdata;
        O_FALL: if (hi) fall[NP-1:DW] <= reg_wdata; else fall[DW-1:0] <= reg_wdata;
        O_RISE: if (hi) rise[NP-1:DW] <= reg_wdata; else rise[DW-1:0] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (hold & ((stat & ~clr) | cond)) | (~hold & cond);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat & en);
  end

  always_comb begin
    mapped  = !reg_addr[0];
    rd_next = '0;
    case (base)
      O_STAT: rd_next = hi ? stat[NP-1:DW] : stat[DW-1:0];
      O_EN:   rd_next = hi ? en[NP-1:DW]   : en[DW-1:0];
      O_TYPE: rd_next = hi ? typ[NP-1:DW]  : typ[DW-1:0];
      O_POL:  rd_next = hi ? pol[NP-1:DW]  : pol[DW-1:0];
      O_HOLD: rd_next = hi ? hold[NP-1:DW] : hold[DW-1:0];
      O_FALL: rd_next = hi ? fall[NP-1:DW] : fall[DW-1:0];
      O_RISE: rd_next = hi ? rise[NP-1:DW] : rise[DW-1:0];
      default: mapped = 1'b0;
    endcase
    if (!mapped) rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq);
  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> (reg_rdata == '0));

  for (genvar i = 0; i < NP; i++) begin : g_chk
    a_r4_level_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (hold[i] && !typ[i] && lvl[i]) |=> stat[i]);
    a_r3_through_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold[i] && !cond[i]) |=> !stat[i]);
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (hold[i] && stat[i] && !clr[i]) |=> stat[i]);
  end
endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pin_in = '1;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", 32'(irq), 0);
    for (int a = 8'h0C; a <= 8'h26; a += 2) begin
      if (a == 8'h1C || a == 8'h1E) continue;
      rd(6'(a), d);
      chk("R1 config zero", 32'(d), 0);
    end
    rd(6'h08, d); chk("R1 status low", 32'(d), 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(6'h10, 16'hA5A5); rd(6'h10, d); chk("R2 type readback", 32'(d), 32'hA5A5);
    wr(6'h16, 16'h3C00); rd(6'h16, d); chk("R2 polarity readback", 32'(d), 32'h3C00);
    wr(6'h10, 16'h0000); wr(6'h16, 16'h0000);
    rd(6'h04, d); chk("R2 unmapped 0x04", 32'(d), 0);
    rd(6'h1C, d); chk("R2 unmapped 0x1C", 32'(d), 0);
    rd(6'h28, d); chk("R2 unmapped 0x28", 32'(d), 0);
  endtask

  task automatic t_level_through();
    logic [15:0] d;
    wr(6'h14, 16'h0008); settle();
    rd(6'h08, d); chk("R3 active-high high", 32'(d), 32'h0008);
    pin_in[3] = 0; settle();
    rd(6'h08, d); chk("R3 active-high low", 32'(d), 0);
    wr(6'h14, 16'h0000); settle();
    rd(6'h08, d); chk("R3 active-low low", 32'(d), 32'h0008);
    pin_in[3] = 1; settle();
    rd(6'h08, d); chk("R3 active-low high", 32'(d), 0);
  endtask

  task automatic t_level_hold();
    logic [15:0] d;
    wr(6'h18, 16'h0020);
    pin_in[5] = 0; settle();
    rd(6'h08, d); chk("R4 set", 32'(d), 32'h0020);
    wr(6'h08, 16'h0020); settle();
    rd(6'h08, d); chk("R4 clear while active", 32'(d), 32'h0020);
    pin_in[5] = 1; settle();
    rd(6'h08, d); chk("R4 held after inactive", 32'(d), 32'h0020);
    wr(6'h08, 16'h0020); settle();
    rd(6'h08, d); chk("R4 clear after inactive", 32'(d), 0);
    wr(6'h18, 16'h0000);
  endtask

  task automatic t_edge_hold();
    logic [15:0] d;
    wr(6'h24, 16'h0001); wr(6'h20, 16'h0000);
    wr(6'h18, 16'h0001); wr(6'h10, 16'h0001);
    pin_in[0] = 0; settle();
    rd(6'h08, d); chk("R5 falling ignored", 32'(d), 0);
    pin_in[0] = 1; settle();
    rd(6'h08, d); chk("R5 rising detected", 32'(d), 32'h0001);
    wr(6'h08, 16'h0000); settle();
    rd(6'h08, d); chk("R6 write 0 keeps", 32'(d), 32'h0001);
    wr(6'h08, 16'h0001); settle();
    rd(6'h08, d); chk("R6 write 1 clears", 32'(d), 0);
    wr(6'h24, 16'h0000); wr(6'h20, 16'h0001);
    pin_in[0] = 0; settle();
    rd(6'h08, d); chk("R5 falling detected", 32'(d), 32'h0001);
    wr(6'h08, 16'h0001);
    pin_in[0] = 1; settle();
    rd(6'h08, d); chk("R5 rising ignored", 32'(d), 0);
    wr(6'h24, 16'h0001);
    pin_in[0] = 0; settle();
    rd(6'h08, d); chk("R5 both: fall", 32'(d), 32'h0001);
    wr(6'h08, 16'h0001);
    pin_in[0] = 1; settle();
    rd(6'h08, d); chk("R5 both: rise", 32'(d), 32'h0001);
    wr(6'h08, 16'h0001);
    wr(6'h10, 0); wr(6'h18, 0); wr(6'h20, 0); wr(6'h24, 0);
  endtask

  task automatic t_high_bank_irq();
    logic [15:0] d;
    wr(6'h1A, 16'h0010);
    pin_in[20] = 0; settle();
    rd(6'h0A, d); chk("R9 high status bit4", 32'(d), 32'h0010);
    rd(6'h08, d); chk("R9 low bank untouched", 32'(d), 0);
    chk("R8 masked irq", 32'(irq), 0);
    wr(6'h0E, 16'h0010); settle();
    chk("R8 irq asserted", 32'(irq), 1);
    wr(6'h0E, 16'h0000); settle();
    chk("R8 irq removed", 32'(irq), 0);
    pin_in[20] = 1; settle();
    wr(6'h0A, 16'h0010); wr(6'h1A, 0); settle();
    rd(6'h0A, d); chk("R9 high clear", 32'(d), 0);
  endtask

  task automatic t_edge_pulse();
    int n = 0;
    wr(6'h12, 16'h0002); wr(6'h26, 16'h0002); wr(6'h0E, 16'h0002);
    pin_in[17] = 0; settle();
    chk("R7 no irq on unselected edge", 32'(irq), 0);
    pin_in[17] = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq) n++;
    end
    chk("R7 single cycle pulse", 32'(n), 1);
    wr(6'h0E, 0); wr(6'h12, 0); wr(6'h26, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_regs();
    t_level_through();
    t_level_hold();
    t_edge_hold();
    t_high_bank_irq();
    t_edge_pulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule